// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM that is one bit wide. The RAM has a 20-bit address, separate data-in and data-out pins, an active-low chip enable and an active-low write enable. The host presents one read or one write at a time on a valid/ready handshake. The controller turns each request into a pin-level cycle built from counted clock phases: an address setup phase with both enables high, a strobe phase, and a hold phase with both enables high. A read adds a one-cycle response phase.

The length of every phase is a whole number of system clocks. Each length is the device's nanosecond minimum divided by the clock period, rounded up. The timing parameters are in nanoseconds, so a faster or slower part or clock only needs new parameter values. Read data is sampled on the last clock of the read strobe and handed back with a single-cycle valid pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, reqReady is 1, sramCeN and sramWeN are both 1, and rspValid is 0.
- R2: reqReady is 1 only while the controller is idle. A request is taken on a clock edge where reqValid and reqReady are both 1. A request held while reqReady is 0 waits, and is taken once reqReady returns.
- R3: Address and write data are registered when a request is taken. Both enables stay high for at least one setup cycle before the strobe begins.
- R4: A write drives sramCeN and sramWeN low together for exactly max(ceil(25 ns / Tclk), ceil(13 ns / Tclk)) cycles (5 at 200 MHz). Both then rise in the same cycle.
- R5: A write ends with both enables high for the longer of ceil(5 ns / Tclk) cycles and the cycles needed to make the whole cycle at least ceil(45 ns / Tclk). At 200 MHz, reqReady is 1 again at the 10th falling clock edge after the accepting edge.
- R6: A read holds sramCeN low and sramWeN high for exactly ceil(45 ns / Tclk) cycles (9 at 200 MHz). sramWeN never falls during a read. Data is sampled on the last of these cycles.
- R7: rspValid is 1 for exactly one cycle, at the 12th falling clock edge after a read is taken (200 MHz). At that point rspRdata equals the bit last written to that address.
- R8: sramAddr changes only while sramCeN and sramWeN are both high. Neither enable changes while sramCeN stays low.
- R9: All 20 address bits are decoded. A write to one address does not change the bit read back from any other address, including address 0 and the all-ones address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | 1 | Bit to write |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspRdata | output | 1 | Captured read bit |
| sramAddr | output | ADDR_W | RAM address pins |
| sramCeN | output | 1 | RAM chip enable, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramDin | output | 1 | RAM data-in pin |
| sramDout | input | 1 | RAM data-out pin |

## Verification
A phase counter or state that slips by a single clock shows up within one request. It changes the length of the enable-low window or the cycle in which reqReady or rspValid returns. The bench measures all of these in whole cycles against values it computes from the nanosecond minimums. A capture made one cycle too early reads a RAM model whose output is valid only after the full access time, so the returned bit is wrong on the first read. A stale address or data register shows as a wrong bit on a later read, or as an address change while an enable is low, which the bench's pin monitor counts.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RESP
  } phase_t;

  typedef struct packed {
    logic load;      // register address and write data
    logic ceActive;  // chip enable asserted
    logic weActive;  // write enable asserted
    logic capture;   // sample the RAM output
  } strobes_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int WR_CYC      = 5,
  parameter int RD_CYC      = 9,
  parameter int WR_HOLD_CYC = 3,
  parameter int RD_HOLD_CYC = 1,
  parameter int CNT_W       = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output logic     rspValid,
  output strobes_t strb
);

  phase_t            phase;
  logic              isWrite;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lastCnt;
  logic              lastCycle;

  always_comb begin
    unique case (phase)
      ST_SETUP:  lastCnt = CNT_W'(SETUP_CYC - 1);
      ST_STROBE: lastCnt = isWrite ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      ST_HOLD:   lastCnt = isWrite ? CNT_W'(WR_HOLD_CYC - 1) : CNT_W'(RD_HOLD_CYC - 1);
      default:   lastCnt = '0;
    endcase
  end

  assign lastCycle = (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      isWrite <= 1'b0;
      cnt     <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          cnt <= '0;
          if (reqValid) begin
            isWrite <= reqWrite;
            phase   <= ST_SETUP;
          end
        end
        ST_RESP: begin
          cnt   <= '0;
          phase <= ST_IDLE;
        end
        default: begin
          if (lastCycle) begin
            cnt <= '0;
            unique case (phase)
              ST_SETUP:  phase <= ST_STROBE;
              ST_STROBE: phase <= ST_HOLD;
              default:   phase <= isWrite ? ST_IDLE : ST_RESP;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign reqReady      = (phase == ST_IDLE);
  assign rspValid      = (phase == ST_RESP);
  assign strb.load     = (phase == ST_IDLE) && reqValid;
  assign strb.ceActive = (phase == ST_STROBE);
  assign strb.weActive = (phase == ST_STROBE) && isWrite;
  assign strb.capture  = (phase == ST_STROBE) && !isWrite && lastCycle;

  assert_load_when_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !reqReady);

  assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.ceActive) |-> $past(!strb.ceActive && !reqReady));

  assert_we_ce_fall_together_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.weActive) |-> $fell(strb.ceActive));

  assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWdata,
  input  logic              sramDout,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramDin,
  output logic              rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic              dinQ;
  logic              rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dinQ   <= 1'b0;
      rdataQ <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        dinQ  <= reqWdata;
      end
      if (strb.capture) begin
        rdataQ <= sramDout;
      end
    end
  end

  assign sramAddr = addrQ;
  assign sramDin  = dinQ;
  assign sramCeN  = !strb.ceActive;
  assign sramWeN  = !strb.weActive;
  assign rspRdata = rdataQ;

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(addrQ) && $stable(dinQ));

  assert_capture_in_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !sramCeN && sramWeN);

  assert_no_load_in_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> sramCeN && sramWeN);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CLK_NS      = 5,
  parameter int T_CYCLE_NS  = 45,
  parameter int T_ACCESS_NS = 45,
  parameter int T_WP_NS     = 25,
  parameter int T_DS_NS     = 13,
  parameter int T_AS_NS     = 0,
  parameter int T_AH_NS     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWdata,
  output logic              rspValid,
  output logic              rspRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramDin,
  input  logic              sramDout
);

  localparam int SETUP_CYC   = imax(1, cdiv(T_AS_NS, CLK_NS));
  localparam int WR_CYC      = imax(1, imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DS_NS, CLK_NS)));
  localparam int RD_CYC      = imax(1, cdiv(T_ACCESS_NS, CLK_NS));
  localparam int TOTAL_CYC   = cdiv(T_CYCLE_NS, CLK_NS);
  localparam int WR_HOLD_CYC = imax(imax(1, cdiv(T_AH_NS, CLK_NS)), TOTAL_CYC - SETUP_CYC - WR_CYC);
  localparam int RD_HOLD_CYC = imax(1, TOTAL_CYC - SETUP_CYC - RD_CYC);
  localparam int MAX_CYC     = imax(imax(SETUP_CYC, WR_CYC), imax(RD_CYC, imax(WR_HOLD_CYC, RD_HOLD_CYC)));
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  strobes_t strb;

  sram_ctrl_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .WR_CYC     (WR_CYC),
    .RD_CYC     (RD_CYC),
    .WR_HOLD_CYC(WR_HOLD_CYC),
    .RD_HOLD_CYC(RD_HOLD_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .strb    (strb)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .sramDout(sramDout),
    .sramAddr(sramAddr),
    .sramCeN (sramCeN),
    .sramWeN (sramWeN),
    .sramDin (sramDin),
    .rspRdata(rspRdata)
  );

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb;

  localparam int AW        = 20;
  localparam int TCLK      = 5;
  localparam int B_SETUP   = 1;
  localparam int B_WR      = (25 + TCLK - 1) / TCLK;
  localparam int B_RD      = (45 + TCLK - 1) / TCLK;
  localparam int B_CYC     = (45 + TCLK - 1) / TCLK;
  localparam int B_WHOLD   = (B_CYC - B_SETUP - B_WR > 1) ? B_CYC - B_SETUP - B_WR : 1;
  localparam int B_RHOLD   = 1;
  localparam int EXP_WRDY  = B_SETUP + B_WR + B_WHOLD + 1;
  localparam int EXP_RSP   = B_SETUP + B_RD + B_RHOLD + 1;

  typedef struct packed {
    logic          w;
    logic [AW-1:0] a;
    logic          d;
    logic          e;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 20'h00000, 1'b1, 1'b0},
    '{1'b1, 20'hFFFFF, 1'b1, 1'b0},
    '{1'b1, 20'h5A5A5, 1'b0, 1'b0},
    '{1'b1, 20'h00001, 1'b1, 1'b0},
    '{1'b0, 20'h00000, 1'b0, 1'b1},
    '{1'b0, 20'hFFFFF, 1'b0, 1'b1},
    '{1'b0, 20'h5A5A5, 1'b0, 1'b0},
    '{1'b0, 20'h00001, 1'b0, 1'b1},
    '{1'b1, 20'h00000, 1'b0, 1'b0},
    '{1'b0, 20'h00000, 1'b0, 1'b0},
    '{1'b0, 20'h80000, 1'b0, 1'b0},
    '{1'b0, 20'hFFFFF, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqWdata = 1'b0;
  logic          rspValid;
  logic          rspRdata;
  logic [AW-1:0] sramAddr;
  logic          sramCeN;
  logic          sramWeN;
  logic          sramDin;
  logic          sramDout = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  sram_cycle_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramDin(sramDin), .sramDout(sramDout)
  );

  always #2.5 clk = ~clk;

  // Behavioural RAM and pin monitor, evaluated at falling edges
  bit            mem [int];
  int            wRun = 0, rRun = 0, lastWLen = 0, lastRLen = 0, protoErr = 0;
  logic [AW-1:0] wAddr = '0, prevAddr = '0;
  logic          wDat = 1'b0, prevCe = 1'b1, prevWe = 1'b1;

  function automatic bit memRd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (sramAddr != prevAddr && !(sramCeN && prevCe && sramWeN && prevWe)) protoErr++;
      if (!sramCeN && !prevCe && sramWeN != prevWe) protoErr++;
      if (!sramWeN && sramCeN) protoErr++;
      if (!sramCeN && !sramWeN) begin
        wRun++; wAddr = sramAddr; wDat = sramDin;
      end else if (wRun > 0) begin
        lastWLen = wRun; mem[int'(wAddr)] = wDat; wRun = 0;
      end
      if (!sramCeN && sramWeN) rRun++;
      else begin
        if (rRun > 0) lastRLen = rRun;
        rRun = 0;
      end
      sramDout = (!sramCeN && sramWeN && rRun >= B_RD) ? memRd(sramAddr) : ~memRd(sramAddr);
      prevAddr = sramAddr; prevCe = sramCeN; prevWe = sramWeN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one request; returns falling edges from accept to completion
  task automatic doReq(input logic w, input logic [AW-1:0] a, input logic d,
                       output int lat, output logic rd);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    rd = 1'b0;
    if (w) begin
      while (!reqReady && lat < 60) begin @(negedge clk); lat++; end
    end else begin
      while (!rspValid && lat < 60) begin @(negedge clk); lat++; end
      rd = rspRdata;
      @(negedge clk);
      check(!rspValid, "R7 pulse width", int'(rspValid), 0);
      check(rspRdata == rd, "R7 data held", int'(rspRdata), int'(rd));
    end
  endtask

  initial begin
    #(200000 * TCLK);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int   lat;
    logic rd;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && sramCeN && sramWeN && !rspValid, "R1 reset state",
          {reqReady, sramCeN, sramWeN, rspValid}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && sramCeN && sramWeN && !rspValid, "R1 after release",
          {reqReady, sramCeN, sramWeN, rspValid}, 4'b1110);

    for (int i = 0; i < 12; i++) begin
      doReq(VEC[i].w, VEC[i].a, VEC[i].d, lat, rd);
      if (VEC[i].w) begin
        check(lat == EXP_WRDY, "R5 write cycle length", lat, EXP_WRDY);
        check(lastWLen == B_WR, "R4 write strobe width", lastWLen, B_WR);
      end else begin
        check(lat == EXP_RSP, "R7 read latency", lat, EXP_RSP);
        check(lastRLen == B_RD, "R6 read strobe width", lastRLen, B_RD);
        check(rd == VEC[i].e, "R9 read data by address", int'(rd), int'(VEC[i].e));
      end
    end

    // R2: request held while busy waits until ready returns
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 20'h12345; reqWdata = 1'b1;
    @(negedge clk);
    reqAddr = 20'h0ABCD; reqWdata = 1'b1;
    lat = 1;
    check(!reqReady, "R2 ready low when busy", int'(reqReady), 0);
    while (!reqReady && lat < 60) begin @(negedge clk); lat++; end
    check(lat == EXP_WRDY, "R2 second request waits", lat, EXP_WRDY);
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R2 held request taken", int'(reqReady), 0);
    doReq(1'b0, 20'h0ABCD, 1'b0, lat, rd);
    check(rd == 1'b1, "R2 queued write landed", int'(rd), 1);
    doReq(1'b0, 20'h12345, 1'b0, lat, rd);
    check(rd == 1'b1, "R3 first write data", int'(rd), 1);
    doReq(1'b0, 20'h00000, 1'b0, lat, rd);
    check(rd == 1'b0, "R9 neighbour untouched", int'(rd), 0);

    repeat (3) @(negedge clk);
    check(protoErr == 0, "R8 enables high around address change", protoErr, 0);
    check(sramCeN && sramWeN && reqReady, "R3 idle enables high",
          {sramCeN, sramWeN, reqReady}, 3'b111);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule